// File: doc/BRIEF.md
# NAND Prefetch Read Engine

The engine fetches a programmed number of bytes from an 8-bit NAND data bus on its own. It places them in an internal byte FIFO, and software drains that FIFO as 32-bit words. Software sets up a configuration register and a byte-count register, then writes 1 to a control register to launch the transfer. The control register reads nonzero while the engine is busy. While it is busy, any attempt to reconfigure is rejected.

While the transfer runs, a status register gives two figures: the number of bytes not yet fetched and the live FIFO fill level. Software polls it and reads a word from the data port each time four or more bytes are buffered.

The byte stream into the FIFO has back-pressure from two sources. A read strobe is issued only when the FIFO has a free byte and the selected NAND wait pin reports ready. The data port is the consumer. A pop happens only when four or more bytes are held. A read with fewer than four bytes returns zero and records an underflow.

Register map (word index on `reg_addr`):
- 0: config.
- 1: byte count.
- 2: control.
- 3: status.
- 4: data port.
- 5: pin status.

Top module: `nand_prefetch_engine`

## Requirements
- R1: After reset, the following all read 0: config, count, control and status. All chip-select outputs are high and the read strobe is low.
- R2: A control write with bit 0 = 1 starts a transfer only under all of these conditions: the engine is idle, config enable (bit 7) is 1, config direction (bit 0) is 0, and the threshold (bits 14:8) is 64 or less. While active, control bit 0 reads 1. A refused start leaves control at 0. The direction bit, where 1 means write posting, is stored and reads back.
- R3: A threshold above 64 never starts a transfer, and no read strobe follows.
- R4: While a transfer is active, writes to config and count are ignored.
- R5: The read strobe is high for one cycle per byte and is always followed by a low cycle. Each byte is captured into the FIFO at the edge that ends its strobe. A strobe is issued only while the FIFO holds fewer than 64 bytes and the wait pin chosen by config bit 4 is high. Only the chip select numbered by config bits 25:24 is driven low, and only while the engine is active.
- R6: The status register holds the following fields:
  - bits 13:0: the count of bytes not yet strobed;
  - bits 30:24: the FIFO fill;
  - bit 16: active and fill at or above the threshold;
  - bit 17: the underflow flag.
- R7: A data-port read with 4 or more bytes buffered removes 4 bytes and returns them little-endian. The first byte fetched lands in bits 7:0.
- R8: A data-port read with fewer than 4 bytes buffered returns 0, removes nothing and sets status bit 17. The next accepted start clears that bit.
- R9: When the remaining count is 0, the FIFO is empty and no strobe is outstanding, control clears to 0 by itself and all chip selects go high.
- R10: Writing control with bit 0 = 0 stops the engine at once and empties the FIFO. The remaining count becomes 0, and a following config write of 0 leaves everything idle.
- R11: Pin-status bits 9:8 show wait pins 1:0 as they were one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| nand_ce_n_o | output | NUM_CS | Active-low chip selects |
| nand_re_o | output | 1 | Read strobe; byte is sampled at the edge that ends it |
| nand_dq_i | input | 8 | NAND data byte |
| nand_wait_i | input | 2 | Ready/busy wait pins, high = ready |

## Verification
Register read data becomes valid one edge after the read strobe. The bench drives every access on a falling edge and samples `reg_rdata` at the next falling edge.

The engine needs one edge after a start to raise its first strobe. Each byte then costs two cycles: a strobe cycle, with capture at the edge that ends it, followed by a gap cycle. Completion clears control one edge after the last word leaves.

Because of this, fetch progress is not counted in cycles. The bench polls status until the expected fill and remaining count appear. It then waits extra cycles to show that nothing more moves, for example on a full FIFO or a busy wait pin, before it compares strobe counts, words and flags.

// File: rtl/nand_pf_pkg.sv
`timescale 1ns/1ps
package nand_pf_pkg;
  localparam logic [2:0] A_CFG  = 3'd0;
  localparam logic [2:0] A_CNT  = 3'd1;
  localparam logic [2:0] A_CTL  = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_DATA = 3'd4;
  localparam logic [2:0] A_PINS = 3'd5;

  localparam int THR_MAX   = 64;
  localparam int B_DIR     = 0;
  localparam int B_WSEL    = 4;
  localparam int B_EN      = 7;
  localparam int B_THR     = 8;
  localparam int THR_W     = 7;
  localparam int B_CS      = 24;
  localparam int B_THRHIT  = 16;
  localparam int B_UFLOW   = 17;
  localparam int B_FILL    = 24;
  localparam int B_PINS    = 8;

  typedef struct packed {
    logic             dir;
    logic             wsel;
    logic             en;
    logic [THR_W-1:0] thr;
  } cfg_t;
endpackage

// File: rtl/nand_pf_fifo.sv
`timescale 1ns/1ps
module nand_pf_fifo #(
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [7:0]                   push_byte,
  input  logic                         pop,
  output logic [31:0]                  pop_word,
  output logic [$clog2(DEPTH+1)-1:0]   fill
);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int FILL_W = $clog2(DEPTH+1);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= push_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= rd_ptr + PTR_W'(4);
      fill <= fill + (push ? FILL_W'(1) : FILL_W'(0)) - (pop ? FILL_W'(4) : FILL_W'(0));
    end
  end

  // little-endian packing: oldest byte in the low lane
  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign pop_word[8*g +: 8] = mem[rd_ptr + PTR_W'(g)];
  end
endmodule

// File: rtl/nand_pf_seq.sv
`timescale 1ns/1ps
module nand_pf_seq #(
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 14,
  parameter int NUM_CS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        active,
  input  logic                        load,
  input  logic [CNT_W-1:0]            load_cnt,
  input  logic                        abort,
  input  logic [$clog2(NUM_CS)-1:0]   cs_sel,
  input  logic                        ready,
  input  logic [$clog2(DEPTH+1)-1:0]  fill,
  output logic [CNT_W-1:0]            remaining,
  output logic                        re_q,
  output logic                        push,
  output logic [NUM_CS-1:0]           ce_n
);
  localparam int FILL_W = $clog2(DEPTH+1);

  logic issue;
  assign issue = active && !abort && !re_q && (remaining != '0) && ready &&
                 (fill < FILL_W'(DEPTH));
  assign push  = re_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      re_q      <= 1'b0;
      remaining <= '0;
    end else begin
      re_q <= issue;
      if (abort)      remaining <= '0;
      else if (load)  remaining <= load_cnt;
      else if (issue) remaining <= remaining - CNT_W'(1);
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_ce
    assign ce_n[i] = !(active && (cs_sel == i[$clog2(NUM_CS)-1:0]));
  end
endmodule

// File: rtl/nand_pf_regs.sv
`timescale 1ns/1ps
module nand_pf_regs
  import nand_pf_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 14,
  parameter int NUM_CS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic                        reg_rd,
  input  logic [2:0]                  reg_addr,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  input  logic [$clog2(DEPTH+1)-1:0]  fill,
  input  logic [CNT_W-1:0]            remaining,
  input  logic                        fetch_busy,
  input  logic [31:0]                 pop_word,
  input  logic [1:0]                  wait_q,
  output logic                        active,
  output logic                        start,
  output logic                        stop,
  output logic                        pop,
  output cfg_t                        cfg,
  output logic [$clog2(NUM_CS)-1:0]   cfg_cs,
  output logic [CNT_W-1:0]            cfg_cnt
);
  localparam int FILL_W = $clog2(DEPTH+1);
  localparam int CS_W   = $clog2(NUM_CS);

  logic        underflow, done, wr_cfg, wr_cnt, rd_data, can_pop;
  logic [31:0] rd_mux;

  assign wr_cfg  = reg_wr && (reg_addr == A_CFG) && !active;
  assign wr_cnt  = reg_wr && (reg_addr == A_CNT) && !active;
  assign start   = reg_wr && (reg_addr == A_CTL) && reg_wdata[0] && !active &&
                   cfg.en && !cfg.dir && (32'(cfg.thr) <= THR_MAX);
  assign stop    = reg_wr && (reg_addr == A_CTL) && !reg_wdata[0];
  assign done    = active && (remaining == '0) && (fill == '0) && !fetch_busy;
  assign rd_data = reg_rd && (reg_addr == A_DATA);
  assign can_pop = fill >= FILL_W'(4);
  assign pop     = rd_data && can_pop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg       <= '0;
      cfg_cs    <= '0;
      cfg_cnt   <= '0;
      active    <= 1'b0;
      underflow <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (wr_cfg) begin
        cfg.dir  <= reg_wdata[B_DIR];
        cfg.wsel <= reg_wdata[B_WSEL];
        cfg.en   <= reg_wdata[B_EN];
        cfg.thr  <= reg_wdata[B_THR +: THR_W];
        cfg_cs   <= reg_wdata[B_CS +: CS_W];
      end
      if (wr_cnt) cfg_cnt <= reg_wdata[CNT_W-1:0];
      if (start)             active <= 1'b1;
      else if (stop || done) active <= 1'b0;
      if (start)                    underflow <= 1'b0;
      else if (rd_data && !can_pop) underflow <= 1'b1;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      A_CFG: begin
        rd_mux[B_DIR]            = cfg.dir;
        rd_mux[B_WSEL]           = cfg.wsel;
        rd_mux[B_EN]             = cfg.en;
        rd_mux[B_THR +: THR_W]   = cfg.thr;
        rd_mux[B_CS +: CS_W]     = cfg_cs;
      end
      A_CNT:  rd_mux[CNT_W-1:0] = cfg_cnt;
      A_CTL:  rd_mux[0] = active;
      A_STAT: begin
        rd_mux[CNT_W-1:0]        = remaining;
        rd_mux[B_THRHIT]         = active && (32'(fill) >= 32'(cfg.thr));
        rd_mux[B_UFLOW]          = underflow;
        rd_mux[B_FILL +: FILL_W] = fill;
      end
      A_DATA: rd_mux = can_pop ? pop_word : 32'd0;
      A_PINS: rd_mux[B_PINS +: 2] = wait_q;
      default: rd_mux = '0;
    endcase
  end
endmodule

// File: rtl/nand_prefetch_engine.sv
`timescale 1ns/1ps
module nand_prefetch_engine
  import nand_pf_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 14,
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NUM_CS-1:0] nand_ce_n_o,
  output logic              nand_re_o,
  input  logic [7:0]        nand_dq_i,
  input  logic [1:0]        nand_wait_i
);
  localparam int FILL_W = $clog2(DEPTH+1);
  localparam int CS_W   = $clog2(NUM_CS);

  logic [FILL_W-1:0] fill;
  logic [CNT_W-1:0]  remaining, cfg_cnt;
  logic [CS_W-1:0]   cfg_cs;
  logic [31:0]       pop_word;
  logic [1:0]        wait_q;
  logic              active, start, stop, pop, push, ready;
  cfg_t              cfg;

  always_ff @(posedge clk) begin
    if (!rst_n) wait_q <= 2'b00;
    else        wait_q <= nand_wait_i;
  end
  assign ready = wait_q[cfg.wsel];

  nand_pf_regs #(.DEPTH(DEPTH), .CNT_W(CNT_W), .NUM_CS(NUM_CS)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fill(fill), .remaining(remaining), .fetch_busy(nand_re_o),
    .pop_word(pop_word), .wait_q(wait_q), .active(active), .start(start),
    .stop(stop), .pop(pop), .cfg(cfg), .cfg_cs(cfg_cs), .cfg_cnt(cfg_cnt)
  );

  nand_pf_seq #(.DEPTH(DEPTH), .CNT_W(CNT_W), .NUM_CS(NUM_CS)) u_seq (
    .clk(clk), .rst_n(rst_n), .active(active), .load(start),
    .load_cnt(cfg_cnt), .abort(stop), .cs_sel(cfg_cs), .ready(ready),
    .fill(fill), .remaining(remaining), .re_q(nand_re_o), .push(push),
    .ce_n(nand_ce_n_o)
  );

  nand_pf_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(stop), .push(push),
    .push_byte(nand_dq_i), .pop(pop), .pop_word(pop_word), .fill(fill)
  );
endmodule

// File: rtl/nand_pf_chk.sv
`timescale 1ns/1ps
module nand_pf_chk #(
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 14,
  parameter int NUM_CS = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       active,
  input logic                       ready,
  input logic                       nand_re_o,
  input logic [NUM_CS-1:0]          nand_ce_n_o,
  input logic [$clog2(DEPTH+1)-1:0] fill,
  input logic [CNT_W-1:0]           remaining
);
  a_r5_strobe_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    nand_re_o |-> active);
  a_r5_single_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    nand_re_o |=> !nand_re_o);
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fill) <= DEPTH);
  a_r5_stall_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> !nand_re_o);
  a_r5_one_chip_select: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ($countones(~nand_ce_n_o) == 1));
  a_r9_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (&nand_ce_n_o));
  a_r6_count_per_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_re_o && $past(rst_n)) |-> (remaining == $past(remaining) - CNT_W'(1)));
endmodule

bind nand_prefetch_engine nand_pf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .ready(ready),
  .nand_re_o(nand_re_o), .nand_ce_n_o(nand_ce_n_o), .fill(fill),
  .remaining(remaining)
);

// File: tb/nand_prefetch_engine_bench.sv
`timescale 1ns/1ps
module nand_prefetch_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [3:0]  nand_ce_n_o;
  logic        nand_re_o;
  logic [7:0]  nand_dq_i;
  logic [1:0]  nand_wait_i = 2'b11;
  int n_chk = 0, n_err = 0, idx = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nand_prefetch_engine u_nand_prefetch_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .nand_ce_n_o(nand_ce_n_o), .nand_re_o(nand_re_o),
    .nand_dq_i(nand_dq_i), .nand_wait_i(nand_wait_i)
  );

  // byte source: advances one byte per strobe
  function automatic logic [7:0] bval(int i);
    return 8'((i * 37 + 5) ^ (i >> 3));
  endfunction
  assign nand_dq_i = bval(idx);
  always @(posedge clk) if (nand_re_o) idx <= idx + 1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  function automatic logic [31:0] cfgw(int dir, int wsel, int en, int thr, int cs);
    return 32'(dir) | (32'(wsel) << 4) | (32'(en) << 7) | (32'(thr) << 8) | (32'(cs) << 24);
  endfunction

  task automatic poll(int want_fill, int want_rem, string tag);
    logic [31:0] s;
    for (int k = 0; k < 3000; k++) begin
      rd(3'd3, s);
      if (s[30:24] == 7'(want_fill) && s[13:0] == 14'(want_rem)) return;
    end
    check(tag, {s[30:24], 11'd0, s[13:0]}, {7'(want_fill), 11'd0, 14'(want_rem)});
  endtask

  task automatic drain(int base, int nwords, string tag);
    logic [31:0] s, w;
    for (int k = 0; k < nwords; k++) begin
      for (int t = 0; t < 3000; t++) begin
        rd(3'd3, s);
        if (s[30:24] >= 7'd4) break;
      end
      rd(3'd4, w);
      check(tag, w, {bval(base+4*k+3), bval(base+4*k+2), bval(base+4*k+1), bval(base+4*k)});
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(3'd0, d); check("R1 config", d, 0);
    rd(3'd1, d); check("R1 count", d, 0);
    rd(3'd2, d); check("R1 control", d, 0);
    rd(3'd3, d); check("R1 status", d, 0);
    check("R1 ce_n", 32'(nand_ce_n_o), 32'hF);
    check("R1 strobe", 32'(nand_re_o), 0);
  endtask

  task automatic t_basic;
    logic [31:0] d; int base;
    wr(3'd0, cfgw(0, 0, 1, 8, 2)); wr(3'd1, 16);
    base = idx; wr(3'd2, 1);
    poll(16, 0, "R5 fetch 16");
    repeat (6) @(negedge clk);
    check("R5 strobes", idx - base, 16);
    check("R5 ce_n", 32'(nand_ce_n_o), 32'hB);
    rd(3'd2, d); check("R2 busy", d, 1);
    rd(3'd3, d); check("R6 status", d, {1'b0, 7'd16, 6'd0, 1'b0, 1'b1, 16'd0});
    drain(base, 4, "R7 word");
    repeat (3) @(negedge clk);
    rd(3'd2, d); check("R9 auto idle", d, 0);
    check("R9 ce_n", 32'(nand_ce_n_o), 32'hF);
  endtask

  task automatic t_reject;
    logic [31:0] d; int base;
    base = idx;
    wr(3'd0, cfgw(0, 0, 1, 65, 0)); wr(3'd1, 8); wr(3'd2, 1);
    repeat (10) @(negedge clk);
    rd(3'd2, d); check("R3 thr 65 refused", d, 0);
    check("R3 no strobes", idx - base, 0);
    wr(3'd0, cfgw(1, 0, 1, 8, 0)); wr(3'd2, 1);
    repeat (6) @(negedge clk);
    rd(3'd2, d); check("R2 write-post refused", d, 0);
    rd(3'd0, d); check("R2 dir stored", d, cfgw(1, 0, 1, 8, 0));
    wr(3'd0, cfgw(0, 0, 0, 8, 0)); wr(3'd2, 1);
    repeat (6) @(negedge clk);
    rd(3'd2, d); check("R2 disabled refused", d, 0);
    check("R2 no strobes", idx - base, 0);
  endtask

  task automatic t_wait_busy;
    logic [31:0] d; int base;
    nand_wait_i = 2'b10;
    wr(3'd0, cfgw(0, 0, 1, 4, 1)); wr(3'd1, 8);
    base = idx; wr(3'd2, 1);
    repeat (20) @(negedge clk);
    rd(3'd3, d); check("R5 stall on wait", d, 32'd8);
    rd(3'd5, d); check("R11 pins", d, 32'h200);
    wr(3'd1, 99); rd(3'd1, d); check("R4 count locked", d, 8);
    wr(3'd0, 0);  rd(3'd0, d); check("R4 config locked", d, cfgw(0, 0, 1, 4, 1));
    nand_wait_i = 2'b11;
    poll(8, 0, "R5 resume");
    drain(base, 2, "R7 word");
    repeat (3) @(negedge clk);
    rd(3'd2, d); check("R9 auto idle", d, 0);
  endtask

  task automatic t_full;
    logic [31:0] d; int base;
    wr(3'd0, cfgw(0, 1, 1, 64, 3)); wr(3'd1, 100);
    base = idx; wr(3'd2, 1);
    poll(64, 36, "R5 fill to full");
    repeat (12) @(negedge clk);
    rd(3'd3, d); check("R5 full holds", d, {1'b0, 7'd64, 6'd0, 1'b0, 1'b1, 2'd0, 14'd36});
    check("R5 strobes at full", idx - base, 64);
    drain(base, 25, "R7 word");
    repeat (3) @(negedge clk);
    rd(3'd2, d); check("R9 auto idle", d, 0);
  endtask

  task automatic t_under_stop;
    logic [31:0] d; int base;
    rd(3'd4, d); check("R8 empty read", d, 0);
    rd(3'd3, d); check("R8 sticky", d, 32'h0002_0000);
    wr(3'd0, cfgw(0, 0, 1, 2, 0)); wr(3'd1, 6);
    base = idx; wr(3'd2, 1);
    rd(3'd3, d); check("R8 cleared by start", 32'(d[17]), 0);
    poll(6, 0, "R5 fetch 6");
    drain(base, 1, "R7 word");
    rd(3'd4, d); check("R8 short read", d, 0);
    rd(3'd3, d); check("R8 nothing removed", d, {1'b0, 7'd2, 6'd0, 1'b1, 1'b1, 16'd0});
    wr(3'd2, 0); wr(3'd0, 0);
    rd(3'd2, d); check("R10 stopped", d, 0);
    rd(3'd3, d); check("R10 flushed", d, 32'h0002_0000);
    check("R10 ce_n", 32'(nand_ce_n_o), 32'hF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_reject();
    t_wait_busy();
    t_full();
    t_under_stop();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule